// File: doc/BRIEF.md
# Keyed Fractional Clock Generator Bank

This block is a bank of five programmable clock generator channels: three general-purpose outputs, one for an audio serial link and one for a pulse-width modulator. Each channel owns a control word and a divisor word on a simple 32-bit register bus. It picks one of several source clocks, divides it by an integer divisor with an optional 12-bit fraction, and drives a gated output clock. A write only lands when its top byte carries the key value, so stray stores cannot retune a running clock.

Source clocks are modelled as plain level inputs. They are sampled in the bus clock domain, which must run well above the fastest source. Software stops a channel by clearing its enable bit. It then polls the busy bit until it reads low, writes the divisor, writes the control word with enable low, and finally sets enable and polls until busy reads high. The channel never truncates an output pulse when it is stopped gracefully. A kill bit stops it at once.

Top module: `clkgen_bank`

## Requirements
- R1: A register write lands only when `bus_wdata[31:24]` equals 0x5A. With any other key the register keeps its old value. Reads return 0 in bits 31:24.
- R2: Control words for channels 0..4 sit at byte addresses 0x70, 0x78, 0x80, 0x98 and 0xA0. The control fields are: mode in bits 10:9, invert in bit 8, busy (read-only) in bit 7, kill in bit 5, enable in bit 4 and source index in bits 3:0. All other bits read 0, and every register reads 0 after reset.
- R3: Divisor words sit at the control address plus 4. The integer divisor is in bits 23:12 and the fraction in bits 11:0.
- R4: With mode 0 and an integer divisor N ≥ 2, the output period is N source periods. The output is high for floor(N/2) of them, and the fraction is ignored.
- R5: With a nonzero mode and N ≥ 2, the fraction is added to a 12-bit accumulator at the end of every output cycle. Each carry out of that accumulator lengthens the next output cycle by one source period.
- R6: An integer divisor of 0 or 1 passes the selected source through unchanged while the channel runs.
- R7: After enable is set, busy goes high at the next rising source edge (in pass-through mode, once the source is low). While busy is low the output sits at its idle level.
- R8: When enable is cleared on a running channel, the current output cycle completes. Busy then falls, and no further output pulse appears.
- R9: While busy is high, writes to the divisor word and to the source and mode fields are ignored.
- R10: Setting kill stops the output and clears busy within two bus clocks, without waiting for the cycle to end. The channel stays stopped while kill is set.
- R11: The invert bit flips the output polarity, so an idle inverted channel drives 1.
- R12: A source index at or above the number of source inputs selects a constant-low source, so an enabled channel never starts.
- R13: Reads from addresses that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, key in the top byte |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | NUM_SRC | Source clock levels |
| gen_clk | output | 5 | Generated clock per channel |

## Verification
A wrong divide count, a wrong accumulator width or a wrong carry shows up as a wrong output period within a few output cycles. The bench therefore times four consecutive periods and one high phase for each programmed setting. A stop path that ends early shows up as a shortened high phase on the pulse in flight when enable is cleared. A kill path that waits instead shows up as a high output two bus clocks after the kill write. A broken key check or busy lock shows up at the next register read, because the rejected value would otherwise be read back.

// File: rtl/clkgen_pkg.sv
// Package: shared constants of the clock generator bank.
// Holds the write key, the field positions of the control and divisor
// words, and the address map of the five channels.
package clkgen_pkg;
    localparam int          NUM_CH   = 5;
    localparam int          DIV_W    = 12;
    localparam int          FRAC_W   = 12;
    localparam int          SEL_W    = 4;
    localparam int          MODE_W   = 2;
    localparam logic [7:0]  WR_KEY   = 8'h5A;
    localparam int          KEY_LSB  = 24;
    localparam int          MODE_LSB = 9;
    localparam int          INV_BIT  = 8;
    localparam int          BUSY_BIT = 7;
    localparam int          KILL_BIT = 5;
    localparam int          ENAB_BIT = 4;
    localparam int          INT_LSB  = 12;

    // Byte address of a channel's control word; its divisor is at +4.
    function automatic logic [7:0] ctl_offset(input int ch);
        case (ch)
            0:       return 8'h70;
            1:       return 8'h78;
            2:       return 8'h80;
            3:       return 8'h98;
            default: return 8'hA0;
        endcase
    endfunction
endpackage

// File: rtl/clkgen_src_edge.sv
// Module: samples every source clock into the bus clock domain and flags
// rising edges. Assumes the bus clock is at least twice the fastest source.
module clkgen_src_edge #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_SRC-1:0] src_lvl,
    output logic [NUM_SRC-1:0] src_rise
);
    logic [NUM_SRC-1:0] lvl_q;
    logic [NUM_SRC-1:0] lvl_qq;

    // Two sampling stages: current level and the level one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            lvl_qq <= '0;
        end else begin
            lvl_q  <= src_in;
            lvl_qq <= lvl_q;
        end
    end

    // A rise is a sampled high that was low one clock earlier.
    always_comb begin
        src_lvl  = lvl_q;
        src_rise = lvl_q & ~lvl_qq;
    end
endmodule

// File: rtl/clkgen_regs.sv
// Module: control and divisor registers of one channel.
// Checks the key, and locks the divisor, source and mode while the channel
// is busy. Assumes wr_ctl and wr_div are never high together.
module clkgen_regs
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_div,
    input  logic [31:0]       wdata,
    input  logic              busy,
    output logic [SEL_W-1:0]  src_sel,
    output logic [MODE_W-1:0] mode,
    output logic              inv,
    output logic              kill,
    output logic              enab,
    output logic [DIV_W-1:0]  divi,
    output logic [FRAC_W-1:0] divf
);
    logic key_ok;

    // Key check on the top byte of every write.
    always_comb key_ok = (wdata[31:KEY_LSB] == WR_KEY);

    // Control word: enable, kill and invert always; source and mode when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= '0;
            mode    <= '0;
            inv     <= 1'b0;
            kill    <= 1'b0;
            enab    <= 1'b0;
        end else if (wr_ctl && key_ok) begin
            inv  <= wdata[INV_BIT];
            kill <= wdata[KILL_BIT];
            enab <= wdata[ENAB_BIT];
            if (!busy) begin
                src_sel <= wdata[SEL_W-1:0];
                mode    <= wdata[MODE_LSB+MODE_W-1:MODE_LSB];
            end
        end
    end

    // Divisor word: accepted only with a valid key and an idle channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divi <= '0;
            divf <= '0;
        end else if (wr_div && key_ok && !busy) begin
            divi <= wdata[INT_LSB+DIV_W-1:INT_LSB];
            divf <= wdata[FRAC_W-1:0];
        end
    end

    assert_bad_key_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_ctl || wr_div) && wdata[31:KEY_LSB] != WR_KEY)
        |=> $stable({src_sel, mode, inv, kill, enab, divi, divf}));

    assert_divisor_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({divi, divf, src_sel, mode}));
endmodule

// File: rtl/clkgen_divider.sv
// Module: the divider of one channel, with its run state.
// Counts rising source edges, stretches a cycle on fractional carries, and
// stops only at a cycle boundary unless killed. Divisor inputs are assumed
// stable while busy (the register block enforces that).
module clkgen_divider #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 12,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_lvl,
    input  logic              src_rise,
    input  logic              enab,
    input  logic              kill,
    input  logic [MODE_W-1:0] mode,
    input  logic              inv,
    input  logic [DIV_W-1:0]  divi,
    input  logic [FRAC_W-1:0] divf,
    output logic              busy,
    output logic              gen_clk
);
    localparam int CNT_W = DIV_W + 1;

    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [FRAC_W-1:0] acc;
    logic             stretch;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic [FRAC_W:0]  acc_sum;
    logic             bypass;
    logic             frac_en;
    logic             last;
    logic             start_ok;
    logic             out_raw;

    // Derived cycle length, high-phase length and accumulator sum.
    always_comb begin
        bypass   = (divi[DIV_W-1:1] == '0);
        frac_en  = |mode;
        period   = {1'b0, divi} + CNT_W'(stretch);
        half     = {2'b00, divi[DIV_W-1:1]};
        last     = (cnt == period - 1'b1);
        acc_sum  = {1'b0, acc} + {1'b0, divf};
        start_ok = bypass ? !src_lvl : src_rise;
        out_raw  = run & (bypass ? src_lvl : (cnt < half));
    end

    // Run state, cycle counter and fractional accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            run     <= 1'b0;
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
        end else if (!run) begin
            cnt     <= '0;
            acc     <= '0;
            stretch <= 1'b0;
            if (enab && start_ok) run <= 1'b1;
        end else if (bypass) begin
            if (!enab && !src_lvl) run <= 1'b0;
        end else if (src_rise) begin
            if (last) begin
                cnt <= '0;
                if (frac_en) begin
                    acc     <= acc_sum[FRAC_W-1:0];
                    stretch <= acc_sum[FRAC_W];
                end else begin
                    stretch <= 1'b0;
                end
                if (!enab) run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Output polarity and busy flag.
    always_comb begin
        busy    = run;
        gen_clk = out_raw ^ inv;
    end

    assert_clean_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(run) && !$past(kill)) |-> !$past(out_raw));

    assert_kill_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !run);

    assert_count_in_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass) |-> (cnt < period));
endmodule

// File: rtl/clkgen_bank.sv
// Module: top of the clock generator bank.
// Decodes the register bus, instantiates one register block and one divider
// per channel, selects each channel's source and assembles read data.
// Assumes word-aligned single-cycle writes.
module clkgen_bank
    import clkgen_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_CH-1:0]  gen_clk
);
    logic [NUM_SRC-1:0] src_lvl;
    logic [NUM_SRC-1:0] src_rise;
    logic [31:0]        ctl_word [NUM_CH];
    logic [31:0]        div_word [NUM_CH];
    logic [NUM_CH-1:0]  busy;
    logic [NUM_CH-1:0]  inv_q;

    clkgen_src_edge #(.NUM_SRC(NUM_SRC)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .src_lvl  (src_lvl),
        .src_rise (src_rise)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [7:0] CTL_A = ctl_offset(ch);
        localparam logic [7:0] DIV_A = CTL_A + 8'd4;

        logic              wr_ctl, wr_div;
        logic [SEL_W-1:0]  src_sel;
        logic [MODE_W-1:0] mode;
        logic              inv, kill, enab;
        logic [DIV_W-1:0]  divi;
        logic [FRAC_W-1:0] divf;
        logic              sel_lvl, sel_rise;

        // Address decode of this channel's two words.
        always_comb begin
            wr_ctl = bus_wr && (bus_addr == CTL_A);
            wr_div = bus_wr && (bus_addr == DIV_A);
        end

        clkgen_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (wr_ctl),
            .wr_div  (wr_div),
            .wdata   (bus_wdata),
            .busy    (busy[ch]),
            .src_sel (src_sel),
            .mode    (mode),
            .inv     (inv),
            .kill    (kill),
            .enab    (enab),
            .divi    (divi),
            .divf    (divf)
        );

        // Source select; an out-of-range index selects constant low.
        always_comb begin
            sel_lvl  = 1'b0;
            sel_rise = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_sel == SEL_W'(s)) begin
                    sel_lvl  = src_lvl[s];
                    sel_rise = src_rise[s];
                end
            end
        end

        clkgen_divider #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .MODE_W(MODE_W)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_lvl  (sel_lvl),
            .src_rise (sel_rise),
            .enab     (enab),
            .kill     (kill),
            .mode     (mode),
            .inv      (inv),
            .divi     (divi),
            .divf     (divf),
            .busy     (busy[ch]),
            .gen_clk  (gen_clk[ch])
        );

        // Read images of the two words, key field returned as zero.
        always_comb begin
            inv_q[ch]    = inv;
            ctl_word[ch] = {8'h00, 13'h0000, mode, inv, busy[ch], 1'b0, kill, enab, src_sel};
            div_word[ch] = {8'h00, divi, divf};
        end

        assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[ch] |-> (gen_clk[ch] == inv_q[ch]));
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ctl_offset(c))         bus_rdata = ctl_word[c];
            if (bus_addr == ctl_offset(c) + 8'd4)  bus_rdata = div_word[c];
        end
    end
endmodule

// File: tb/clkgen_bank_tb.sv
`timescale 1ns/1ps
module clkgen_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_in = '0;
    logic [4:0]  gen_clk;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;

    clkgen_bank #(.NUM_SRC(4)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .gen_clk   (gen_clk)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Source 0: period 4 clocks. Source 1: period 6 clocks. Others low.
    always @(negedge clk) src_in <= {2'b00, 1'((cyc / 3) % 2), 1'((cyc / 2) % 2)};

    typedef struct packed {
        logic [2:0]  ch;
        logic [3:0]  src;
        logic [1:0]  mode;
        logic [11:0] divi;
        logic [11:0] divf;
        logic [15:0] sum4;
        logic [15:0] high;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd0, 4'd0, 2'd0, 12'd2, 12'h000, 16'd32, 16'd4},
        '{3'd1, 4'd0, 2'd0, 12'd5, 12'h000, 16'd80, 16'd8},
        '{3'd2, 4'd1, 2'd0, 12'd3, 12'h000, 16'd72, 16'd6},
        '{3'd3, 4'd0, 2'd1, 12'd4, 12'h800, 16'd72, 16'd8},
        '{3'd4, 4'd0, 2'd1, 12'd4, 12'h400, 16'd68, 16'd8},
        '{3'd0, 4'd0, 2'd0, 12'd4, 12'h800, 16'd64, 16'd8},
        '{3'd1, 4'd0, 2'd0, 12'd1, 12'h000, 16'd16, 16'd2},
        '{3'd2, 4'd1, 2'd1, 12'd0, 12'h800, 16'd24, 16'd3},
        '{3'd3, 4'd1, 2'd2, 12'd2, 12'h400, 16'd54, 16'd6}
    };

    function automatic logic [7:0] ctl_a(input int ch);
        case (ch)
            0: return 8'h70;
            1: return 8'h78;
            2: return 8'h80;
            3: return 8'h98;
            default: return 8'hA0;
        endcase
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Poll busy; returns number of polls used, or -1 on timeout.
    task automatic poll_busy(input int ch, input logic want, output int used);
        logic [31:0] r;
        used = -1;
        for (int i = 0; i < 400; i++) begin
            bus_read(ctl_a(ch), r);
            if (r[7] == want) begin used = i; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_rise(input int ch, output logic ok);
        logic prev;
        ok = 1'b0;
        prev = gen_clk[ch];
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!prev && gen_clk[ch]) begin ok = 1'b1; break; end
            prev = gen_clk[ch];
        end
    endtask

    // Time four output periods and one high phase, skipping early cycles.
    task automatic measure(input int ch, output int sum4, output int high);
        logic prev, in_high;
        int rises, t0;
        rises = 0; t0 = 0; sum4 = -1; high = -1; in_high = 1'b0;
        prev = gen_clk[ch];
        for (int g = 0; g < 3000 && rises < 8; g++) begin
            @(negedge clk);
            if (in_high) begin
                if (gen_clk[ch]) high++;
                else in_high = 1'b0;
            end
            if (!prev && gen_clk[ch]) begin
                rises++;
                if (rises == 4) begin t0 = cyc; high = 1; in_high = 1'b1; end
                if (rises == 8) sum4 = cyc - t0;
            end
            prev = gen_clk[ch];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] r, r0;
        int used, s4, hi;
        logic ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: every register reads zero after reset; outputs low (R7).
        for (int c = 0; c < 5; c++) begin
            bus_read(ctl_a(c), r);       chk("R2 reset ctl", r, 32'h0);
            bus_read(ctl_a(c) + 8'd4, r); chk("R3 reset div", r, 32'h0);
        end
        chk("R7 idle outputs", {27'h0, gen_clk}, 32'h0);
        bus_read(8'h88, r); chk("R13 unmapped 0x88", r, 32'h0);
        bus_read(8'h00, r); chk("R13 unmapped 0x00", r, 32'h0);

        // Vector table: program each channel with the required sequence.
        for (int v = 0; v < 9; v++) begin
            int ch;
            string tag;
            ch = int'(VECS[v].ch);
            if (VECS[v].divi < 2)      tag = "R6 pass-through";
            else if (VECS[v].mode != 0) tag = "R5 fractional";
            else                        tag = "R4 integer";
            bus_write(ctl_a(ch), 32'h5A00_0000);
            poll_busy(ch, 1'b0, used);
            chk("R8 busy low before reprogram", 32'(used >= 0), 32'h1);
            bus_write(ctl_a(ch) + 8'd4, {8'h5A, VECS[v].divi, VECS[v].divf});
            bus_write(ctl_a(ch), {8'h5A, 13'h0, VECS[v].mode, 5'h00, VECS[v].src});
            bus_write(ctl_a(ch), {8'h5A, 13'h0, VECS[v].mode, 5'h01, VECS[v].src});
            poll_busy(ch, 1'b1, used);
            chk("R7 busy rises after enable", 32'(used >= 0), 32'h1);
            measure(ch, s4, hi);
            chk({tag, " four periods"}, 32'(s4), 32'(VECS[v].sum4));
            chk({tag, " high phase"}, 32'(hi), 32'(VECS[v].high));
        end

        // R1: wrong key leaves the control word unchanged.
        bus_write(ctl_a(4), 32'h5A00_0000);
        poll_busy(4, 1'b0, used);
        bus_read(ctl_a(4), r0);
        bus_write(ctl_a(4), 32'hA500_0011);
        repeat (20) @(negedge clk);
        bus_read(ctl_a(4), r);
        chk("R1 bad key ignored", r, r0);

        // R1 R2 R3: field readback with key field returned as zero.
        bus_write(ctl_a(4), 32'h5A00_0523);
        bus_read(ctl_a(4), r); chk("R2 control fields", r, 32'h0000_0523);
        bus_write(ctl_a(4) + 8'd4, 32'h5AAB_C123);
        bus_read(ctl_a(4) + 8'd4, r); chk("R3 divisor fields", r, 32'h00AB_C123);
        // R11: invert set on an idle channel drives 1; clearing drives 0.
        chk("R11 inverted idle", 32'(gen_clk[4]), 32'h1);
        bus_write(ctl_a(4), 32'h5A00_0000);
        chk("R11 normal idle", 32'(gen_clk[4]), 32'h0);

        // R9: locks while busy; invert still writable.
        bus_write(ctl_a(0), 32'h5A00_0000);
        poll_busy(0, 1'b0, used);
        bus_write(ctl_a(0) + 8'd4, 32'h5A00_5000);
        bus_write(ctl_a(0), 32'h5A00_0010);
        poll_busy(0, 1'b1, used);
        bus_write(ctl_a(0) + 8'd4, 32'h5A00_3000);
        bus_read(ctl_a(0) + 8'd4, r); chk("R9 divisor locked", r, 32'h0000_5000);
        bus_write(ctl_a(0), 32'h5A00_0211);
        bus_read(ctl_a(0), r); chk("R9 source and mode locked", r, 32'h0000_0090);
        bus_write(ctl_a(0), 32'h5A00_0110);
        bus_read(ctl_a(0), r); chk("R11 invert while busy", r, 32'h0000_0190);
        bus_write(ctl_a(0), 32'h5A00_0010);

        // R8: clearing enable right after a rise keeps the full high phase.
        wait_rise(0, ok);
        hi = 1;
        bus_addr = ctl_a(0); bus_wdata = 32'h5A00_0000; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (gen_clk[0]) hi++;
        for (int i = 0; i < 40 && gen_clk[0]; i++) begin
            @(negedge clk);
            if (gen_clk[0]) hi++;
        end
        chk("R8 high phase kept on stop", 32'(hi), 32'd8);
        bus_read(ctl_a(0), r); chk("R8 busy held to cycle end", 32'(r[7]), 32'h1);
        poll_busy(0, 1'b0, used);
        chk("R8 busy falls at cycle end", 32'(used >= 0 && used <= 16), 32'h1);
        r = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (gen_clk[0]) r = 1; end
        chk("R8 no pulse after stop", r, 32'h0);

        // R10: kill stops at once even mid high phase.
        bus_write(ctl_a(0), 32'h5A00_0010);
        poll_busy(0, 1'b1, used);
        wait_rise(0, ok);
        bus_write(ctl_a(0), 32'h5A00_0030);
        @(negedge clk);
        chk("R10 output low after kill", 32'(gen_clk[0]), 32'h0);
        bus_read(ctl_a(0), r); chk("R10 busy cleared by kill", 32'(r[7]), 32'h0);
        r = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (gen_clk[0]) r = 1; end
        chk("R10 held stopped while kill set", r, 32'h0);
        bus_write(ctl_a(0), 32'h5A00_0000);

        // R12: out-of-range source index never starts.
        bus_write(ctl_a(2), 32'h5A00_0000);
        poll_busy(2, 1'b0, used);
        bus_write(ctl_a(2) + 8'd4, 32'h5A00_2000);
        bus_write(ctl_a(2), 32'h5A00_0007);
        bus_write(ctl_a(2), 32'h5A00_0017);
        r = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (gen_clk[2]) r = 1; end
        chk("R12 no output from absent source", r, 32'h0);
        bus_read(ctl_a(2), r); chk("R12 busy stays low", 32'(r[7]), 32'h0);

        report();
        $finish;
    end
endmodule